// File: doc/BRIEF.md
# Paged Tag Memory Command Controller

This block carries out page reads and page writes on a small non-volatile style memory of 44 pages, each four bytes wide, held in flip-flops. A host front end (framing, CRC and authentication live elsewhere) presents an operation code, an 8-bit page address, up to 16 bytes of write payload and a one-cycle `start` strobe. One clock later the block raises `done` for a single cycle. Alongside it comes a 4-bit acknowledge code and, for reads, a 16-byte response.

Page 02h holds protection bits that can only be set, and each bit freezes one user page against writing. Page 03h is a one-time-programmable page whose bits can only go from 0 to 1. Pages 00h and 01h hold a fixed identifier that is loaded at reset and can never be written. A separate `write_ok` input from an outside authentication unit gates all writes to the user region. Reads are never blocked by any of these controls. A read gathers four consecutive pages and wraps past the last page back to page 00h.

Top module: `tagmem_ctrl`

## Requirements
- R1: After reset, `done` is 0, `ack` is 0 and `rdata` is 0. Pages 00h and 01h hold `UID_SEED` (page 00h = bits 31:0) and every other page reads as zero.
- R2: Any operation with `addr` above 2Bh gets NAK (`ack` = 0h) and changes nothing. The reserved operation code 3 also gets NAK at any address.
- R3: READ (`op` = 0) at an address from 00h to 2Bh gets ACK (`ack` = Ah). `rdata` holds four consecutive pages: bits 31:0 = page `addr`, bits 63:32 = the next page, and so on. Within a page, byte n sits at bits 8n+7:8n.
- R4: Read addressing wraps modulo 44. A READ at 2Bh returns pages 2Bh, 00h, 01h and 02h, in that order, from low bits to high bits.
- R5: WRITE (`op` = 1) to a writable page stores `wdata[31:0]` into that single page and gets ACK. Neighbouring pages are unchanged.
- R6: COMPATIBILITY WRITE (`op` = 2) stores only `wdata[31:0]` (bytes 0 to 3). Bytes 4 to 15 have no effect on any page.
- R7: Writes to page 03h and to page 02h OR the payload into the stored value, so bits can be set but never cleared.
- R8: Bit i of page 02h bits 27:16 (i = 0..11) locks page 04h+i. A write to a locked page gets NAK and leaves the page unchanged. Pages 10h and above have no lock bit.
- R9: Writes to pages 00h and 01h always get NAK and leave the identifier intact.
- R10: While `write_ok` is low, writes to pages 04h and above get NAK. Writes to pages 02h and 03h do not depend on `write_ok`.
- R11: Reads get ACK whatever the lock bits and `write_ok` are.
- R12: Every `start` produces exactly one `done` pulse in the following cycle, and no `done` appears without a preceding `start`. While `done` is high, `ack` is either Ah or 0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle command strobe |
| op | input | 2 | 0 read, 1 write, 2 compatibility write, 3 reserved |
| addr | input | 8 | Page address |
| wdata | input | 128 | Write payload, byte n at bits 8n+7:8n |
| write_ok | input | 1 | Write permission from the authentication unit |
| rdata | output | 128 | Four-page read response |
| ack | output | 4 | Ah on acceptance, 0h on refusal |
| done | output | 1 | Result valid for one cycle |

## Verification
The bench builds the block with its default geometry: 44 pages, 12 lock bits starting at page 04h, and a 16-byte read window. It overrides `UID_SEED` with a distinctive pattern so that the identifier pages can be told apart from cleared pages. With this geometry, the wrap at page 2Bh, the first and last lockable pages (04h, 0Fh) and the first unlockable page (10h) can all be reached with a handful of commands. The identifier showing up in the wrapped read confirms both the ordering and the protection of pages 00h and 01h.

// File: rtl/tagmem_pkg.sv
package tagmem_pkg;

    typedef enum logic [1:0] {
        OP_READ   = 2'd0,
        OP_WRITE  = 2'd1,
        OP_CWRITE = 2'd2,
        OP_RSVD   = 2'd3
    } tag_op_e;

    localparam logic [3:0] CODE_ACK = 4'hA;
    localparam logic [3:0] CODE_NAK = 4'h0;

    typedef struct packed {
        logic rd_grant;
        logic wr_grant;
        logic or_merge;
    } tag_verdict_t;

    function automatic logic op_writes(input tag_op_e o);
        return (o == OP_WRITE) || (o == OP_CWRITE);
    endfunction

endpackage

// File: rtl/tagmem_policy.sv
module tagmem_policy
    import tagmem_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PAGES      = 44,
    parameter int UID_PAGES  = 2,
    parameter int LOCK_PAGE  = 2,
    parameter int OTP_PAGE   = 3,
    parameter int USER_FIRST = 4,
    parameter int NLOCK      = 12
) (
    input  tag_op_e             op,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                write_ok,
    input  logic [NLOCK-1:0]    lock_bits,
    output tag_verdict_t        verdict
);
    localparam int LIW = (NLOCK > 1) ? $clog2(NLOCK) : 1;
    localparam logic [ADDR_W-1:0] A_LIM   = ADDR_W'(PAGES);
    localparam logic [ADDR_W-1:0] A_UID   = ADDR_W'(UID_PAGES);
    localparam logic [ADDR_W-1:0] A_USER  = ADDR_W'(USER_FIRST);
    localparam logic [ADDR_W-1:0] A_LKEND = ADDR_W'(USER_FIRST + NLOCK);
    localparam logic [ADDR_W-1:0] A_OTP   = ADDR_W'(OTP_PAGE);
    localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(LOCK_PAGE);

    logic [ADDR_W-1:0]  rel;
    logic [2**LIW-1:0]  lk_pad;
    logic               in_range;
    logic               in_user;
    logic               locked;

    always_comb begin
        lk_pad   = '0;
        lk_pad[NLOCK-1:0] = lock_bits;
        rel      = addr - A_USER;
        in_range = addr < A_LIM;
        in_user  = addr >= A_USER;
        locked   = in_user && (addr < A_LKEND) && lk_pad[rel[LIW-1:0]];

        verdict.rd_grant = (op == OP_READ) && in_range;
        verdict.wr_grant = op_writes(op) && in_range && (addr >= A_UID)
                           && !(in_user && (!write_ok || locked));
        verdict.or_merge = (addr == A_OTP) || (addr == A_LOCK);
    end

endmodule

// File: rtl/tagmem_store.sv
module tagmem_store #(
    parameter int          PAGES     = 44,
    parameter int          PW        = 32,
    parameter int          UID_PAGES = 2,
    parameter logic [63:0] UID_SEED  = 64'h0807060504030201,
    parameter int          LOCK_PAGE = 2,
    parameter int          LOCK_LSB  = 16,
    parameter int          NLOCK     = 12,
    localparam int         AW        = $clog2(PAGES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [AW-1:0]      waddr,
    input  logic [PW-1:0]      wdata,
    input  logic               or_merge,
    output logic [PAGES*PW-1:0] pages_flat,
    output logic [NLOCK-1:0]   lock_bits
);
    for (genvar p = 0; p < PAGES; p++) begin : g_page
        localparam logic [PW-1:0] INIT =
            (p < UID_PAGES) ? PW'(UID_SEED >> (p * PW)) : '0;
        logic [PW-1:0] word_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= INIT;
            end else if (we && (waddr == AW'(p))) begin
                word_q <= or_merge ? (word_q | wdata) : wdata;
            end
        end

        assign pages_flat[p*PW +: PW] = word_q;
    end

    assign lock_bits = pages_flat[LOCK_PAGE*PW + LOCK_LSB +: NLOCK];

endmodule

// File: rtl/tagmem_gather.sv
module tagmem_gather #(
    parameter int  PAGES = 44,
    parameter int  PW    = 32,
    parameter int  NREAD = 4,
    localparam int AW    = $clog2(PAGES)
) (
    input  logic [PAGES*PW-1:0] pages_flat,
    input  logic [AW-1:0]       base,
    output logic [NREAD*PW-1:0] resp
);
    localparam logic [AW:0] LIM = (AW+1)'(PAGES);

    for (genvar k = 0; k < NREAD; k++) begin : g_slot
        logic [AW:0]   sum;
        logic [AW-1:0] idx;
        always_comb begin
            sum = {1'b0, base} + (AW+1)'(k);
            idx = (sum >= LIM) ? AW'(sum - LIM) : sum[AW-1:0];
        end
        assign resp[k*PW +: PW] = pages_flat[idx*PW +: PW];
    end

endmodule

// File: rtl/tagmem_ctrl.sv
module tagmem_ctrl
    import tagmem_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          PAGES      = 44,
    parameter int          PW         = 32,
    parameter int          NREAD      = 4,
    parameter int          UID_PAGES  = 2,
    parameter logic [63:0] UID_SEED   = 64'h0807060504030201,
    parameter int          LOCK_PAGE  = 2,
    parameter int          OTP_PAGE   = 3,
    parameter int          USER_FIRST = 4,
    parameter int          LOCK_LSB   = 16,
    parameter int          NLOCK      = 12,
    localparam int         AW         = $clog2(PAGES),
    localparam int         RW         = NREAD * PW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [RW-1:0]     wdata,
    input  logic              write_ok,
    output logic [RW-1:0]     rdata,
    output logic [3:0]        ack,
    output logic              done
);
    tag_op_e             op_e;
    tag_verdict_t        verdict;
    logic [PAGES*PW-1:0] pages_flat;
    logic [NLOCK-1:0]    lock_bits;
    logic [RW-1:0]       gathered;
    logic [PW-1:0]       otp_word;
    logic [PW-1:0]       lock_word;
    logic                we;

    assign op_e = tag_op_e'(op);

    tagmem_policy #(
        .ADDR_W(ADDR_W), .PAGES(PAGES), .UID_PAGES(UID_PAGES),
        .LOCK_PAGE(LOCK_PAGE), .OTP_PAGE(OTP_PAGE),
        .USER_FIRST(USER_FIRST), .NLOCK(NLOCK)
    ) u_policy (
        .op(op_e), .addr(addr), .write_ok(write_ok),
        .lock_bits(lock_bits), .verdict(verdict)
    );

    assign we = start && verdict.wr_grant;

    tagmem_store #(
        .PAGES(PAGES), .PW(PW), .UID_PAGES(UID_PAGES), .UID_SEED(UID_SEED),
        .LOCK_PAGE(LOCK_PAGE), .LOCK_LSB(LOCK_LSB), .NLOCK(NLOCK)
    ) u_store (
        .clk(clk), .rst(rst), .we(we), .waddr(addr[AW-1:0]),
        .wdata(wdata[PW-1:0]), .or_merge(verdict.or_merge),
        .pages_flat(pages_flat), .lock_bits(lock_bits)
    );

    tagmem_gather #(
        .PAGES(PAGES), .PW(PW), .NREAD(NREAD)
    ) u_gather (
        .pages_flat(pages_flat), .base(addr[AW-1:0]), .resp(gathered)
    );

    assign otp_word  = pages_flat[OTP_PAGE*PW +: PW];
    assign lock_word = pages_flat[LOCK_PAGE*PW +: PW];

    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            ack   <= CODE_NAK;
            rdata <= '0;
        end else begin
            done <= start;
            if (start) begin
                ack   <= (verdict.rd_grant || verdict.wr_grant) ? CODE_ACK : CODE_NAK;
                rdata <= verdict.rd_grant ? gathered : '0;
            end
        end
    end

endmodule

// File: rtl/tagmem_ctrl_chk.sv
module tagmem_ctrl_chk #(
    parameter int ADDR_W     = 8,
    parameter int PAGES      = 44,
    parameter int PW         = 32,
    parameter int UID_PAGES  = 2,
    parameter int USER_FIRST = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [1:0]        op,
    input logic [ADDR_W-1:0] addr,
    input logic              write_ok,
    input logic [3:0]        ack,
    input logic              done,
    input logic [PW-1:0]     otp_word,
    input logic [PW-1:0]     lock_word
);
    localparam logic [ADDR_W-1:0] A_LIM  = ADDR_W'(PAGES);
    localparam logic [ADDR_W-1:0] A_UID  = ADDR_W'(UID_PAGES);
    localparam logic [ADDR_W-1:0] A_USER = ADDR_W'(USER_FIRST);

    logic is_wr;
    assign is_wr = (op == 2'd1) || (op == 2'd2);

    p_done_after_start_r12: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    p_no_spurious_done_r12: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);
    p_ack_values_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> (ack == 4'hA || ack == 4'h0));
    p_out_of_range_nak_r2: assert property (@(posedge clk) disable iff (rst)
        (start && addr >= A_LIM) |=> (ack == 4'h0));
    p_uid_write_nak_r9: assert property (@(posedge clk) disable iff (rst)
        (start && is_wr && addr < A_UID) |=> (ack == 4'h0));
    p_user_write_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (start && is_wr && addr >= A_USER && !write_ok) |=> (ack == 4'h0));
    p_read_always_ack_r11: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd0 && addr < A_LIM) |=> (ack == 4'hA));
    p_otp_only_sets_r7: assert property (@(posedge clk) disable iff (rst)
        ((otp_word & $past(otp_word)) == $past(otp_word)));
    p_lock_only_sets_r8: assert property (@(posedge clk) disable iff (rst)
        ((lock_word & $past(lock_word)) == $past(lock_word)));

endmodule

bind tagmem_ctrl tagmem_ctrl_chk #(
    .ADDR_W(ADDR_W), .PAGES(PAGES), .PW(PW),
    .UID_PAGES(UID_PAGES), .USER_FIRST(USER_FIRST)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr),
    .write_ok(write_ok), .ack(ack), .done(done),
    .otp_word(otp_word), .lock_word(lock_word)
);

// File: tb/tagmem_ctrl_test.sv
module tagmem_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] SEED = 64'hC0DEFACE_13579BDF;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic        wok;
        logic [3:0]  exp_ack;
        logic        chk_rd;
        logic [31:0] exp_rd0;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 8'h04, 32'h11223344, 1'b1, 4'hA, 1'b0, 32'h0},        // R5
        '{2'd0, 8'h04, 32'h0,        1'b1, 4'hA, 1'b1, 32'h11223344}, // R5
        '{2'd1, 8'h00, 32'hFFFFFFFF, 1'b1, 4'h0, 1'b0, 32'h0},        // R9
        '{2'd0, 8'h00, 32'h0,        1'b1, 4'hA, 1'b1, 32'h13579BDF}, // R9
        '{2'd1, 8'h03, 32'h0000000F, 1'b0, 4'hA, 1'b0, 32'h0},        // R10
        '{2'd2, 8'h03, 32'h000000F0, 1'b0, 4'hA, 1'b0, 32'h0},        // R7
        '{2'd0, 8'h03, 32'h0,        1'b0, 4'hA, 1'b1, 32'h000000FF}, // R7
        '{2'd1, 8'h05, 32'hAAAA5555, 1'b0, 4'h0, 1'b0, 32'h0},        // R10
        '{2'd0, 8'h05, 32'h0,        1'b0, 4'hA, 1'b1, 32'h0},        // R11
        '{2'd1, 8'h2C, 32'h12121212, 1'b1, 4'h0, 1'b0, 32'h0},        // R2
        '{2'd0, 8'h2C, 32'h0,        1'b1, 4'h0, 1'b1, 32'h0},        // R2
        '{2'd0, 8'hFF, 32'h0,        1'b1, 4'h0, 1'b1, 32'h0},        // R2
        '{2'd1, 8'h02, 32'h00020000, 1'b1, 4'hA, 1'b0, 32'h0},        // R8
        '{2'd1, 8'h05, 32'h12345678, 1'b1, 4'h0, 1'b0, 32'h0},        // R8
        '{2'd0, 8'h05, 32'h0,        1'b1, 4'hA, 1'b1, 32'h0},        // R8
        '{2'd1, 8'h04, 32'h99999999, 1'b1, 4'hA, 1'b0, 32'h0},        // R8
        '{2'd0, 8'h04, 32'h0,        1'b1, 4'hA, 1'b1, 32'h99999999}, // R8
        '{2'd1, 8'h02, 32'h00000000, 1'b1, 4'hA, 1'b0, 32'h0},        // R7
        '{2'd0, 8'h02, 32'h0,        1'b1, 4'hA, 1'b1, 32'h00020000}, // R7
        '{2'd3, 8'h04, 32'h77777777, 1'b1, 4'h0, 1'b0, 32'h0},        // R2
        '{2'd1, 8'h27, 32'hCAFEF00D, 1'b1, 4'hA, 1'b0, 32'h0},        // R5
        '{2'd0, 8'h27, 32'h0,        1'b1, 4'hA, 1'b1, 32'hCAFEF00D}, // R5
        '{2'd1, 8'h02, 32'h08000000, 1'b1, 4'hA, 1'b0, 32'h0},        // R8
        '{2'd1, 8'h0F, 32'h01010101, 1'b1, 4'h0, 1'b0, 32'h0},        // R8
        '{2'd1, 8'h10, 32'h0BADBEEF, 1'b1, 4'hA, 1'b0, 32'h0},        // R8
        '{2'd0, 8'h0F, 32'h0,        1'b1, 4'hA, 1'b1, 32'h0},        // R8
        '{2'd0, 8'h10, 32'h0,        1'b0, 4'hA, 1'b1, 32'h0BADBEEF}  // R11
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   op = 2'd0;
    logic [7:0]   addr = 8'h0;
    logic [127:0] wdata = '0;
    logic         write_ok = 1'b0;
    logic [127:0] rdata;
    logic [3:0]   ack;
    logic         done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tagmem_ctrl #(.UID_SEED(SEED)) uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .addr(addr),
        .wdata(wdata), .write_ok(write_ok), .rdata(rdata), .ack(ack), .done(done)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] o, input logic [7:0] a,
                         input logic [127:0] d, input logic wok);
        @(negedge clk);
        op = o; addr = a; wdata = d; write_ok = wok; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R12 done", {127'b0, done}, 128'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done", {127'b0, done}, 128'd0);
        check("R1 ack", {124'b0, ack}, 128'd0);
        check("R1 rdata", rdata, 128'd0);

        issue(2'd0, 8'h20, '0, 1'b0);
        check("R1 cleared pages", rdata, 128'd0);
        @(negedge clk);
        check("R12 single pulse", {127'b0, done}, 128'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].op, VECS[i].addr, {96'h0, VECS[i].data}, VECS[i].wok);
            check($sformatf("vec%0d ack", i), {124'b0, ack}, {124'b0, VECS[i].exp_ack});
            if (VECS[i].chk_rd)
                check($sformatf("vec%0d rdata", i), {96'b0, rdata[31:0]}, {96'b0, VECS[i].exp_rd0});
        end

        // R4: wrap at the last page
        issue(2'd1, 8'h2B, {96'h0, 32'hDEADBEEF}, 1'b1);
        check("R4 write ack", {124'b0, ack}, {124'b0, 4'hA});
        issue(2'd0, 8'h2B, '0, 1'b1);
        check("R4 wrapped read", rdata,
              {32'h08020000, 32'hC0DEFACE, 32'h13579BDF, 32'hDEADBEEF});

        // R3: four consecutive pages
        issue(2'd0, 8'h03, '0, 1'b1);
        check("R3 full read", rdata,
              {32'h00000000, 32'h00000000, 32'h99999999, 32'h000000FF});

        // R6: upper payload bytes ignored
        issue(2'd2, 8'h06, {96'hFFFFFFFF_EEEEEEEE_DDDDDDDD, 32'h5A5AA5A5}, 1'b1);
        check("R6 ack", {124'b0, ack}, {124'b0, 4'hA});
        issue(2'd0, 8'h06, '0, 1'b1);
        check("R6 only bytes 0-3", rdata,
              {32'h00000000, 32'h00000000, 32'h00000000, 32'h5A5AA5A5});

        // R9: identifier intact after refused write to page 01h
        issue(2'd1, 8'h01, {96'h0, 32'h0}, 1'b1);
        check("R9 nak", {124'b0, ack}, 128'd0);
        issue(2'd0, 8'h00, '0, 1'b1);
        check("R9 uid", {64'b0, rdata[63:0]}, {64'b0, SEED});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule